// File: doc/BRIEF.md
# Processor Low-Power State Sequencer

This block follows a processor package through its layered low-power states: Active, Stop-Grant, Sleep, Deep Sleep, Deeper Sleep and an enhanced Deeper Sleep sub-state. A separate active-low request input enters each state. A state can only be entered from the one directly above it. The block also drives a 7-bit voltage ID code that matches the current state. It tells the platform when snoops and interrupts can be accepted, and it asks the platform clock source to stop the bus clock while the package is in Deep Sleep or lower. On the way back up from Deep Sleep, the block holds a settle state for a fixed number of reference-clock cycles before it reports Sleep again. This gives the clock PLL time to stabilise.

The whole block runs on an always-on reference clock, so the settle count keeps going while the bus clock is gated. Two sticky flags report misuse. One reports a request edge that arrives out of order. The other reports bus activity seen between Deep Sleep entry and the return to Stop-Grant. A further output tells the power controller when the core's requested package and performance state call for leaving Deeper Sleep.

Top module: `pwrstate_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the block goes to Active (`pstate` = 0) and `vid` takes the nominal code. `seq_err`, `bus_err` and `clk_stop_req` go low, and `snoop_ok` and `irq_ok` go high.
- R2: The `pstate` codes are Active 0, Stop-Grant 1, Sleep 2, Deep Sleep 3, Deeper Sleep 4, enhanced Deeper Sleep 5 and PLL settle 6. Active moves to Stop-Grant when `stopg_req_n` is low. Stop-Grant returns to Active when `stopg_req_n` is high; otherwise it moves to Sleep when `sleep_req_n` is low. Sleep returns to Stop-Grant when `sleep_req_n` is high. Each of these moves happens at the next clock edge.
- R3: Sleep moves to Deep Sleep when `sleep_req_n` is still low and `deep_req_n` is low. A low `deep_req_n` in any other state causes no entry to Deep Sleep.
- R4: Deep Sleep with `deep_req_n` low and `deeper_req_n` low moves to enhanced Deeper Sleep if `cache_off` is 1, and to base Deeper Sleep otherwise. No other state enters either of them.
- R5: `vid` is `VID_DEEPER` in Deeper Sleep and `VID_ENH` in the enhanced sub-state, where `VID_ENH` < `VID_DEEPER`. In every other state `vid` is `VID_NOM`.
- R6: Deeper Sleep or the enhanced sub-state returns to Deep Sleep at the next edge at which `deeper_req_n` is high.
- R7: `deeper_exit_req` is high only in states 4 and 5. In those states it is high when `core_cstate` is not 4 (the C4 code) or when `core_pstate` is not all ones (the lowest operating point).
- R8: In Deep Sleep, a high `deep_req_n` moves the block to settle (6). The block then stays in settle for exactly `SETTLE_CYC` cycles and moves to Sleep after that.
- R9: `snoop_ok` and `irq_ok` are low in states 3, 4, 5 and 6, and high in states 0, 1 and 2.
- R10: `bus_err` is sticky. It sets one cycle after `bus_act` is seen high in a cycle that lies between Deep Sleep entry from Sleep and the next entry to Stop-Grant.
- R11: `seq_err` is sticky. It sets one cycle after a falling edge of `deep_req_n` while the state is not Sleep, or a falling edge of `deeper_req_n` while the state is not Deep Sleep.
- R12: With `ALLOW_CLK_STOP` = 1, `clk_stop_req` is high one cycle after a cycle in states 3, 4 or 5 with `deep_req_n` low, and low otherwise. It therefore rises one cycle after Deep Sleep entry and falls one cycle after `deep_req_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on reference clock |
| rst | input | 1 | Synchronous active-high reset |
| stopg_req_n | input | 1 | Stop-Grant request, active low |
| sleep_req_n | input | 1 | Sleep request, active low |
| deep_req_n | input | 1 | Deep Sleep request, active low |
| deeper_req_n | input | 1 | Deeper Sleep request, active low |
| cache_off | input | 1 | Last-level cache fully shut down |
| bus_act | input | 1 | Activity seen on the front-side bus inputs |
| core_cstate | input | 3 | Package state requested by the core (4 = C4) |
| core_pstate | input | PST_W | Performance state requested by the core (all ones = lowest) |
| pstate | output | 3 | Current state code |
| vid | output | VID_W | Voltage ID code |
| snoop_ok | output | 1 | Snoops can be accepted |
| irq_ok | output | 1 | Interrupts can be latched |
| clk_stop_req | output | 1 | Bus clock may be stopped |
| deeper_exit_req | output | 1 | Core asks to leave Deeper Sleep |
| seq_err | output | 1 | Sticky out-of-order request flag |
| bus_err | output | 1 | Sticky bus-activity-while-quiesced flag |

## Verification
The hardest situations to reach are the settle exit and the enhanced Deeper Sleep branch. Each needs four request inputs to fall in order and then to stay low for several cycles. Random toggling alone rarely keeps that ordering intact. The stimulus therefore mixes a directed descent and ascent, covering both cache settings and a full settle window, with long stretches in which each request only flips with low probability. It also applies occasional resets, so that the sticky flags clear and the deep states are revisited with and without errors.

// File: rtl/pwrstate_pkg.sv
package pwrstate_pkg;

    typedef enum logic [2:0] {
        PS_ACTIVE     = 3'd0,
        PS_STOPG      = 3'd1,
        PS_SLEEP      = 3'd2,
        PS_DEEP       = 3'd3,
        PS_DEEPER     = 3'd4,
        PS_DEEPER_ENH = 3'd5,
        PS_SETTLE     = 3'd6
    } pstate_e;

    localparam logic [2:0] CSTATE_C4 = 3'd4;

    typedef struct packed {
        logic stopg_n;
        logic sleep_n;
        logic deep_n;
        logic deeper_n;
        logic cache_off;
    } ctrl_t;

    // Deep Sleep or any state below it, including the settle window
    function automatic logic is_quiesced(pstate_e s);
        return (s == PS_DEEP) || (s == PS_DEEPER) ||
               (s == PS_DEEPER_ENH) || (s == PS_SETTLE);
    endfunction

    // States in which the bus clock may be gated
    function automatic logic is_clk_gateable(pstate_e s);
        return (s == PS_DEEP) || (s == PS_DEEPER) || (s == PS_DEEPER_ENH);
    endfunction

    function automatic logic is_deeper(pstate_e s);
        return (s == PS_DEEPER) || (s == PS_DEEPER_ENH);
    endfunction

endpackage

// File: rtl/pwrstate_settle.sv
module pwrstate_settle
    import pwrstate_pkg::*;
#(
    parameter int SETTLE_CYC = 750
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic running,
    output logic done
);
    localparam int CW = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
    localparam logic [CW-1:0] LOAD_VAL = CW'(SETTLE_CYC - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= LOAD_VAL;
        end else if (running && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign done = running && (cnt == '0);

    AST_SETTLE_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt <= LOAD_VAL); // R8

    AST_SETTLE_LOAD: assert property (@(posedge clk) disable iff (rst)
        start |=> (cnt == LOAD_VAL)); // R8

endmodule

// File: rtl/pwrstate_fsm.sv
module pwrstate_fsm
    import pwrstate_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  ctrl_t   ctrl,
    input  logic    settle_done,
    output pstate_e state,
    output pstate_e state_nxt,
    output logic    settle_start
);
    always_comb begin
        state_nxt = state;
        case (state)
            PS_ACTIVE: begin
                if (!ctrl.stopg_n) state_nxt = PS_STOPG;
            end
            PS_STOPG: begin
                if (ctrl.stopg_n)       state_nxt = PS_ACTIVE;
                else if (!ctrl.sleep_n) state_nxt = PS_SLEEP;
            end
            PS_SLEEP: begin
                if (ctrl.sleep_n)      state_nxt = PS_STOPG;
                else if (!ctrl.deep_n) state_nxt = PS_DEEP;
            end
            PS_DEEP: begin
                if (ctrl.deep_n)
                    state_nxt = PS_SETTLE;
                else if (!ctrl.deeper_n)
                    state_nxt = ctrl.cache_off ? PS_DEEPER_ENH : PS_DEEPER;
            end
            PS_DEEPER, PS_DEEPER_ENH: begin
                if (ctrl.deeper_n) state_nxt = PS_DEEP;
            end
            PS_SETTLE: begin
                if (settle_done) state_nxt = PS_SLEEP;
            end
            default: state_nxt = PS_ACTIVE;
        endcase
    end

    assign settle_start = (state == PS_DEEP) && ctrl.deep_n;

    always_ff @(posedge clk) begin
        if (rst) state <= PS_ACTIVE;
        else     state <= state_nxt;
    end

    AST_DEEP_FROM_SLEEP: assert property (@(posedge clk) disable iff (rst)
        (state == PS_DEEP && $past(state) != PS_DEEP) |->
        ($past(state) == PS_SLEEP || is_deeper($past(state)))); // R3

    AST_DEEPER_FROM_DEEP: assert property (@(posedge clk) disable iff (rst)
        (is_deeper(state) && !is_deeper($past(state))) |->
        ($past(state) == PS_DEEP)); // R4

    AST_DEEPER_RETURN: assert property (@(posedge clk) disable iff (rst)
        (is_deeper(state) && ctrl.deeper_n) |=> (state == PS_DEEP)); // R6

    AST_SLEEP_AFTER_SETTLE: assert property (@(posedge clk) disable iff (rst)
        (state == PS_SLEEP && $past(state) == PS_SETTLE) |->
        $past(settle_done)); // R8

endmodule

// File: rtl/pwrstate_guard.sv
module pwrstate_guard
    import pwrstate_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  pstate_e state,
    input  pstate_e state_nxt,
    input  logic    deep_n,
    input  logic    deeper_n,
    input  logic    bus_act,
    output logic    seq_err,
    output logic    bus_err
);
    logic prev_deep_n;
    logic prev_deeper_n;
    logic quiet_win;
    logic deep_fall;
    logic deeper_fall;
    logic bad_order;

    assign deep_fall   = prev_deep_n && !deep_n;
    assign deeper_fall = prev_deeper_n && !deeper_n;
    assign bad_order   = (deep_fall && state != PS_SLEEP) ||
                         (deeper_fall && state != PS_DEEP);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_deep_n   <= 1'b1;
            prev_deeper_n <= 1'b1;
            quiet_win     <= 1'b0;
            seq_err       <= 1'b0;
            bus_err       <= 1'b0;
        end else begin
            prev_deep_n   <= deep_n;
            prev_deeper_n <= deeper_n;
            if (state == PS_SLEEP && state_nxt == PS_DEEP)
                quiet_win <= 1'b1;
            else if (state_nxt == PS_STOPG)
                quiet_win <= 1'b0;
            if (bad_order)
                seq_err <= 1'b1;
            if (quiet_win && bus_act)
                bus_err <= 1'b1;
        end
    end

    AST_BUSERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        bus_err |=> bus_err); // R10

    AST_SEQERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        seq_err |=> seq_err); // R11

    AST_QUIET_IN_DEEP: assert property (@(posedge clk) disable iff (rst)
        is_quiesced(state) |-> quiet_win); // R10

endmodule

// File: rtl/pwrstate_outmap.sv
module pwrstate_outmap
    import pwrstate_pkg::*;
#(
    parameter int              PST_W          = 3,
    parameter int              VID_W          = 7,
    parameter logic [VID_W-1:0] VID_NOM       = 7'h3A,
    parameter logic [VID_W-1:0] VID_DEEPER    = 7'h22,
    parameter logic [VID_W-1:0] VID_ENH       = 7'h1C,
    parameter bit              ALLOW_CLK_STOP = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  pstate_e          state,
    input  logic             deep_n,
    input  logic [2:0]       core_cstate,
    input  logic [PST_W-1:0] core_pstate,
    output logic [VID_W-1:0] vid,
    output logic             snoop_ok,
    output logic             irq_ok,
    output logic             clk_stop_req,
    output logic             deeper_exit_req
);
    localparam logic [PST_W-1:0] PST_LOWEST = '1;

    always_comb begin
        case (state)
            PS_DEEPER:     vid = VID_DEEPER;
            PS_DEEPER_ENH: vid = VID_ENH;
            default:       vid = VID_NOM;
        endcase
    end

    assign snoop_ok = !is_quiesced(state);
    assign irq_ok   = !is_quiesced(state);

    assign deeper_exit_req = is_deeper(state) &&
        ((core_cstate != CSTATE_C4) || (core_pstate != PST_LOWEST));

    generate
        if (ALLOW_CLK_STOP) begin : g_gate
            always_ff @(posedge clk) begin
                if (rst) clk_stop_req <= 1'b0;
                else     clk_stop_req <= is_clk_gateable(state) && !deep_n;
            end
        end else begin : g_run
            assign clk_stop_req = 1'b0;
        end
    endgenerate

    AST_CLK_RESTART: assert property (@(posedge clk) disable iff (rst)
        $rose(deep_n) |=> !clk_stop_req); // R12

    AST_CLK_STOP_SCOPE: assert property (@(posedge clk) disable iff (rst)
        clk_stop_req |-> !snoop_ok); // R12

endmodule

// File: rtl/pwrstate_seq.sv
module pwrstate_seq
    import pwrstate_pkg::*;
#(
    parameter int               SETTLE_CYC     = 750,
    parameter int               PST_W          = 3,
    parameter int               VID_W          = 7,
    parameter logic [VID_W-1:0] VID_NOM        = 7'h3A,
    parameter logic [VID_W-1:0] VID_DEEPER     = 7'h22,
    parameter logic [VID_W-1:0] VID_ENH        = 7'h1C,
    parameter bit               ALLOW_CLK_STOP = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             stopg_req_n,
    input  logic             sleep_req_n,
    input  logic             deep_req_n,
    input  logic             deeper_req_n,
    input  logic             cache_off,
    input  logic             bus_act,
    input  logic [2:0]       core_cstate,
    input  logic [PST_W-1:0] core_pstate,
    output logic [2:0]       pstate,
    output logic [VID_W-1:0] vid,
    output logic             snoop_ok,
    output logic             irq_ok,
    output logic             clk_stop_req,
    output logic             deeper_exit_req,
    output logic             seq_err,
    output logic             bus_err
);
    ctrl_t   ctrl;
    pstate_e state;
    pstate_e state_nxt;
    logic    settle_start;
    logic    settle_done;

    assign ctrl = '{stopg_n:   stopg_req_n,
                    sleep_n:   sleep_req_n,
                    deep_n:    deep_req_n,
                    deeper_n:  deeper_req_n,
                    cache_off: cache_off};

    pwrstate_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .ctrl         (ctrl),
        .settle_done  (settle_done),
        .state        (state),
        .state_nxt    (state_nxt),
        .settle_start (settle_start)
    );

    pwrstate_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
        .clk     (clk),
        .rst     (rst),
        .start   (settle_start),
        .running (state == PS_SETTLE),
        .done    (settle_done)
    );

    pwrstate_guard u_guard (
        .clk       (clk),
        .rst       (rst),
        .state     (state),
        .state_nxt (state_nxt),
        .deep_n    (deep_req_n),
        .deeper_n  (deeper_req_n),
        .bus_act   (bus_act),
        .seq_err   (seq_err),
        .bus_err   (bus_err)
    );

    pwrstate_outmap #(
        .PST_W          (PST_W),
        .VID_W          (VID_W),
        .VID_NOM        (VID_NOM),
        .VID_DEEPER     (VID_DEEPER),
        .VID_ENH        (VID_ENH),
        .ALLOW_CLK_STOP (ALLOW_CLK_STOP)
    ) u_outmap (
        .clk             (clk),
        .rst             (rst),
        .state           (state),
        .deep_n          (deep_req_n),
        .core_cstate     (core_cstate),
        .core_pstate     (core_pstate),
        .vid             (vid),
        .snoop_ok        (snoop_ok),
        .irq_ok          (irq_ok),
        .clk_stop_req    (clk_stop_req),
        .deeper_exit_req (deeper_exit_req)
    );

    assign pstate = state;

    AST_RESET_ACTIVE: assert property (@(posedge clk)
        rst |=> (pstate == 3'd0 && !seq_err && !bus_err)); // R1

    AST_STOPG_PATH: assert property (@(posedge clk) disable iff (rst)
        (pstate == 3'd1 && $past(pstate) != 3'd1) |->
        ($past(pstate) == 3'd0 || $past(pstate) == 3'd2)); // R2

endmodule

// File: tb/pwrstate_seq_test.sv
module pwrstate_seq_test;
    localparam int  N_SET   = 40;
    localparam logic [6:0] V_NOM = 7'h3A;
    localparam logic [6:0] V_DPR = 7'h22;
    localparam logic [6:0] V_ENH = 7'h1C;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic stopg_n = 1'b1, sleep_n = 1'b1, deep_n = 1'b1, deeper_n = 1'b1;
    logic cache_off = 1'b0, bus_act = 1'b0;
    logic [2:0] cst = 3'd4;
    logic [2:0] pst = 3'd7;
    logic [2:0] pstate;
    logic [6:0] vid;
    logic snoop_ok, irq_ok, clk_stop_req, deeper_exit_req, seq_err, bus_err;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // reference model state
    int m_st = 0;
    int m_sc = 0;
    bit m_pd = 1, m_pdr = 1, m_win = 0, m_seq = 0, m_bus = 0, m_clk = 0;
    int prev_st = 0;

    always #10 clk = ~clk;

    pwrstate_seq #(.SETTLE_CYC(N_SET)) uut (
        .clk(clk), .rst(rst),
        .stopg_req_n(stopg_n), .sleep_req_n(sleep_n),
        .deep_req_n(deep_n), .deeper_req_n(deeper_n),
        .cache_off(cache_off), .bus_act(bus_act),
        .core_cstate(cst), .core_pstate(pst),
        .pstate(pstate), .vid(vid), .snoop_ok(snoop_ok), .irq_ok(irq_ok),
        .clk_stop_req(clk_stop_req), .deeper_exit_req(deeper_exit_req),
        .seq_err(seq_err), .bus_err(bus_err)
    );

    task automatic chk(string tag, string what, int got, int exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, got, exp);
        end
    endtask

    function automatic logic [6:0] exp_vid(int s);
        return (s == 4) ? V_DPR : (s == 5) ? V_ENH : V_NOM;
    endfunction

    function automatic string st_tag(int s);
        case (s)
            0, 1:    return "R2";
            2:       return "R3";
            3:       return "R4";
            4, 5:    return "R6";
            default: return "R8";
        endcase
    endfunction

    // advance the model by one edge using the currently driven inputs
    task automatic model_step();
        int ns;
        bit nwin;
        if (rst) begin
            m_st = 0; m_sc = 0; m_pd = 1; m_pdr = 1;
            m_win = 0; m_seq = 0; m_bus = 0; m_clk = 0;
            return;
        end
        ns = m_st;
        case (m_st)
            0: if (!stopg_n) ns = 1;
            1: if (stopg_n) ns = 0; else if (!sleep_n) ns = 2;
            2: if (sleep_n) ns = 1; else if (!deep_n) ns = 3;
            3: if (deep_n) ns = 6; else if (!deeper_n) ns = cache_off ? 5 : 4;
            4, 5: if (deeper_n) ns = 3;
            default: begin
                if (m_sc + 1 == N_SET) ns = 2;
            end
        endcase
        if (m_st == 6) m_sc++; else m_sc = 0;
        nwin = m_win;
        if (m_st == 2 && ns == 3) nwin = 1;
        else if (ns == 1) nwin = 0;
        if ((m_pd && !deep_n && m_st != 2) || (m_pdr && !deeper_n && m_st != 3)) m_seq = 1;
        if (m_win && bus_act) m_bus = 1;
        m_clk = (m_st >= 3 && m_st <= 5) && !deep_n;
        m_win = nwin;
        m_pd = deep_n;
        m_pdr = deeper_n;
        m_st = ns;
    endtask

    task automatic compare_all();
        bit rdy;
        bit ex;
        rdy = !(m_st >= 3 && m_st <= 6);
        ex = (m_st == 4 || m_st == 5) && (cst != 3'd4 || pst != 3'd7);
        chk(st_tag(prev_st), "pstate", pstate, m_st);
        chk("R5", "vid", vid, exp_vid(m_st));
        chk("R9", "snoop_ok", snoop_ok, rdy);
        chk("R9", "irq_ok", irq_ok, rdy);
        chk("R7", "deeper_exit_req", deeper_exit_req, ex);
        chk("R11", "seq_err", seq_err, m_seq);
        chk("R10", "bus_err", bus_err, m_bus);
        chk("R12", "clk_stop_req", clk_stop_req, m_clk);
    endtask

    // one cycle: inputs already driven; edge, then compare off the edge
    task automatic cycle();
        @(posedge clk);
        prev_st = m_st;
        model_step();
        @(negedge clk);
        compare_all();
    endtask

    task automatic hold(int n);
        for (int i = 0; i < n; i++) cycle();
    endtask

    task automatic do_reset();
        rst = 1'b1;
        stopg_n = 1; sleep_n = 1; deep_n = 1; deeper_n = 1; bus_act = 0;
        hold(2);
        rst = 1'b0;
        chk("R1", "reset pstate", pstate, 0);
        chk("R1", "reset vid", vid, V_NOM);
        chk("R1", "reset flags", {seq_err, bus_err, clk_stop_req}, 0);
        chk("R1", "reset ready", {snoop_ok, irq_ok}, 2'b11);
    endtask

    initial begin
        void'($urandom(32'd4242));
        @(negedge clk);
        do_reset();

        // R2 / R3: out-of-order deep request in Active is ignored and flagged
        deep_n = 0; hold(2);
        chk("R3", "no deep entry from Active", pstate, 0);
        chk("R11", "seq_err after early deep", seq_err, 1);
        do_reset();

        // clean descent
        stopg_n = 0; hold(1);
        chk("R2", "Active->Stop-Grant", pstate, 1);
        sleep_n = 0; hold(1);
        chk("R2", "Stop-Grant->Sleep", pstate, 2);
        deep_n = 0; hold(1);
        chk("R3", "Sleep->Deep", pstate, 3);
        hold(1);
        chk("R12", "clock stop raised", clk_stop_req, 1);
        cache_off = 1; deeper_n = 0; hold(1);
        chk("R4", "enhanced entry", pstate, 5);
        chk("R5", "enhanced vid", vid, V_ENH);
        chk("R7", "no exit at C4 lowest", deeper_exit_req, 0);
        pst = 3'd6; hold(1);
        chk("R7", "exit on higher perf state", deeper_exit_req, 1);
        pst = 3'd7; cst = 3'd2; hold(1);
        chk("R7", "exit on other cstate", deeper_exit_req, 1);
        cst = 3'd4;
        deeper_n = 1; hold(1);
        chk("R6", "enhanced->Deep", pstate, 3);
        cache_off = 0; deeper_n = 0; hold(1);
        chk("R4", "base deeper entry", pstate, 4);
        chk("R5", "deeper vid", vid, V_DPR);
        deeper_n = 1; hold(1);
        chk("R6", "deeper->Deep", pstate, 3);
        bus_act = 1; hold(1); bus_act = 0;
        chk("R10", "bus activity in Deep", bus_err, 1);
        deep_n = 1; hold(1);
        chk("R8", "settle start", pstate, 6);
        chk("R12", "clock stop dropped", clk_stop_req, 0);
        hold(N_SET - 1);
        chk("R8", "still settling", pstate, 6);
        hold(1);
        chk("R8", "Sleep after settle", pstate, 2);
        sleep_n = 1; hold(1);
        chk("R2", "Sleep->Stop-Grant", pstate, 1);
        stopg_n = 1; hold(1);
        chk("R2", "Stop-Grant->Active", pstate, 0);
        chk("R11", "clean walk no seq_err", seq_err, 0);
        do_reset();
        bus_act = 1; hold(1); bus_act = 0;
        chk("R10", "bus activity while Active ignored", bus_err, 0);

        // constrained random
        for (int i = 0; i < 6000; i++) begin
            if ($urandom_range(0, 799) == 0) rst = 1'b1; else rst = 1'b0;
            if ($urandom_range(0, 7) == 0) stopg_n = ~stopg_n;
            if ($urandom_range(0, 7) == 0) sleep_n = ~sleep_n;
            if ($urandom_range(0, 9) == 0) deep_n = ~deep_n;
            if ($urandom_range(0, 9) == 0) deeper_n = ~deeper_n;
            cache_off = $urandom_range(0, 1);
            bus_act = ($urandom_range(0, 59) == 0);
            cst = ($urandom_range(0, 1) != 0) ? 3'd4 : 3'($urandom_range(0, 7));
            pst = ($urandom_range(0, 1) != 0) ? 3'd7 : 3'($urandom_range(0, 7));
            if (rst) begin
                stopg_n = 1; sleep_n = 1; deep_n = 1; deeper_n = 1;
            end
            cycle();
        end
        rst = 1'b0;

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule